// File: doc/BRIEF.md
# Overcurrent Debounce, Alert and Shutdown Latch

This block watches a stream of raw 8-bit current samples. Each sample carries the number of the channel it belongs to. Every sample is compared against the threshold of its channel. A breach counts only when the sample is strictly above the threshold. The all-ones threshold code turns a channel's comparator off.

Each channel has two independent consecutive-breach qualifiers, each set by its own 7-bit delay value:

- The first qualifier drives sticky per-channel overcurrent status bits and a level alert output.
- The second qualifier drives a hardware shutdown latch, which an external enable pin gates.

The register interface around the block supplies the thresholds, the two delay values with their hold (reset) bits, and the alert-enable bit. It also supplies strobes for status reads and writes and for a won alert-response arbitration. The serial protocol itself lies outside this block.

Top module: `ocp_monitor`

## Requirements
- R1: A sample breaches when it is strictly greater than its channel's threshold. A threshold of 8'hFF never yields a breach, whatever the sample value.
- R2: With overcurrent delay N (0..127), the status bit of a channel sets on the N+1-th consecutive breaching sample of that channel. N=0 sets it on the first breach. The bit is visible one clock after that sample.
- R3: A non-breaching sample on a channel restarts that channel's run. Samples tagged for other channels neither extend nor break the run.
- R4: Status bits are sticky. A status write with bit i at 0 clears status bit i and restarts that channel's run, so a fresh run of N+1 breaches is needed to set it again. Writing 1 at bit i leaves bit i unchanged.
- R5: While the overcurrent hold bit is 1, all status bits read 0, runs are cleared, and no status bit sets.
- R6: When alert-enable is 1, a status bit going from 0 to 1 raises the alert one clock after the qualifying sample. While alert-enable is 0, the alert is low.
- R7: A status read strobe, a status write strobe or an arbitration-won strobe lowers the alert on the next clock, unless a status bit newly sets in the same cycle.
- R8: With shutdown delay M (0..127), the shutdown output sets after M+1 consecutive breaches on any one channel and stays set. Clearing status bits has no effect on it.
- R9: While the enable pin is low, the shutdown output is 0, the latch is cleared and the shutdown runs restart. After enable returns, a full M+1 run is needed.
- R10: While the shutdown hold bit is 1, the shutdown output is 0 and the shutdown runs are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_chan | input | CH_W | Channel tag of the sample |
| smp_data | input | 8 | Raw sample value |
| thr_vec | input | NUM_CH*8 | Thresholds, channel i at bits [8i+7:8i] |
| oc_limit | input | 7 | Overcurrent delay N |
| oc_hold | input | 1 | Overcurrent hold bit |
| sd_limit | input | 7 | Shutdown delay M |
| sd_hold | input | 1 | Shutdown hold bit |
| alert_en | input | 1 | Alert enable |
| sd_enable | input | 1 | Shutdown enable pin |
| stat_rd | input | 1 | Status read strobe |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | NUM_CH | Status write data, 0 clears a bit |
| arb_won | input | 1 | Alert-response arbitration won strobe |
| oc_status | output | NUM_CH | Sticky overcurrent status bits |
| alert | output | 1 | Alert level, active high |
| shutdown | output | 1 | Shutdown level, active high |

## Verification
A run counter that is off by one shows up at the ports immediately. The status bit sets one sample early or late, in the clock that follows the N+1-th breach, and the alert moves with it. A counter that fails to restart, or that is disturbed by another channel's samples, lets a broken run set a bit that should stay clear. A counter that wraps lets a long breach run drop out of qualification. A stale shutdown latch or shutdown count becomes visible on the first breach after the enable pin or the hold bit is released. The bench keeps a per-channel arithmetic model of both runs and compares all three outputs after every cycle of directed and randomised traffic.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    localparam int SMP_W = 8;
    localparam int DLY_W = 7;
    localparam int CNT_W = DLY_W + 1;

    localparam logic [SMP_W-1:0] THR_OFF = {SMP_W{1'b1}};

    typedef enum logic {
        ALERT_QUIET  = 1'b0,
        ALERT_RAISED = 1'b1
    } alert_state_e;

    typedef struct packed {
        logic             hold;
        logic [DLY_W-1:0] limit;
    } run_cfg_t;

    function automatic logic over_limit(input logic [SMP_W-1:0] smp,
                                        input logic [SMP_W-1:0] thr);
        return (thr != THR_OFF) && (smp > thr);
    endfunction

endpackage

// File: rtl/ocp_breach_cmp.sv
module ocp_breach_cmp
    import ocp_pkg::*;
(
    input  logic [SMP_W-1:0] smp,
    input  logic [SMP_W-1:0] thr,
    output logic             hit
);

    always_comb begin
        hit = over_limit(smp, thr);
    end

endmodule

// File: rtl/ocp_run_counter.sv
module ocp_run_counter
    import ocp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  run_cfg_t cfg,
    input  logic     clr,
    input  logic     step,
    input  logic     hit,
    output logic     qualify
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             flush;

    assign flush = cfg.hold | clr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            cnt_q <= '0;
        end else if (step) begin
            if (hit) begin
                cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign qualify = step & hit & ~flush & (cnt_q >= {1'b0, cfg.limit});

    AST_RUN_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && hit && !flush && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R2

    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
        (step && !hit) |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/ocp_status_alert.sv
module ocp_status_alert
    import ocp_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] qual,
    input  logic [NUM_CH-1:0] wipe,
    input  logic              hold,
    input  logic              access,
    input  logic              arb_won,
    input  logic              alert_en,
    output logic [NUM_CH-1:0] status,
    output logic              alert
);

    logic [NUM_CH-1:0] sts_q;
    logic [NUM_CH-1:0] fresh;
    alert_state_e      al_q;

    assign fresh = qual & ~sts_q & ~wipe & {NUM_CH{~hold}};

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q | qual) & ~wipe;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !alert_en) begin
            al_q <= ALERT_QUIET;
        end else if (|fresh) begin
            al_q <= ALERT_RAISED;
        end else if (access || arb_won) begin
            al_q <= ALERT_QUIET;
        end
    end

    assign status = sts_q;
    assign alert  = (al_q == ALERT_RAISED);

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!hold && wipe == '0) |=> ((status & $past(status)) == $past(status))); // R4

    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        hold |=> (status == '0)); // R5

    AST_ALERT_OFF: assert property (@(posedge clk) disable iff (rst)
        !alert_en |=> !alert); // R6

    AST_ALERT_ACK: assert property (@(posedge clk) disable iff (rst)
        ((access || arb_won) && qual == '0) |=> !alert); // R7

endmodule

// File: rtl/ocp_shutdown_latch.sv
module ocp_shutdown_latch
    import ocp_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] qual,
    input  logic              enable,
    input  logic              hold,
    output logic              shutdown
);

    logic latch_q;

    always_ff @(posedge clk) begin
        if (rst || !enable || hold) begin
            latch_q <= 1'b0;
        end else if (|qual) begin
            latch_q <= 1'b1;
        end
    end

    assign shutdown = latch_q & enable & ~hold;

    AST_SD_STICKY: assert property (@(posedge clk) disable iff (rst)
        (shutdown && enable && !hold) |=> (latch_q || !enable || hold)); // R8

    AST_SD_ENA_LOW: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !latch_q); // R9

    AST_SD_HOLD: assert property (@(posedge clk) disable iff (rst)
        hold |=> !latch_q); // R10

endmodule

// File: rtl/ocp_monitor.sv
module ocp_monitor
    import ocp_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic [CH_W-1:0]         smp_chan,
    input  logic [SMP_W-1:0]        smp_data,
    input  logic [NUM_CH*SMP_W-1:0] thr_vec,
    input  logic [DLY_W-1:0]        oc_limit,
    input  logic                    oc_hold,
    input  logic [DLY_W-1:0]        sd_limit,
    input  logic                    sd_hold,
    input  logic                    alert_en,
    input  logic                    sd_enable,
    input  logic                    stat_rd,
    input  logic                    stat_wr,
    input  logic [NUM_CH-1:0]       stat_wdata,
    input  logic                    arb_won,
    output logic [NUM_CH-1:0]       oc_status,
    output logic                    alert,
    output logic                    shutdown
);

    run_cfg_t          oc_cfg;
    run_cfg_t          sd_cfg;
    logic [NUM_CH-1:0] wipe;
    logic [NUM_CH-1:0] oc_qual;
    logic [NUM_CH-1:0] sd_qual;

    assign oc_cfg = '{hold: oc_hold, limit: oc_limit};
    assign sd_cfg = '{hold: sd_hold | ~sd_enable, limit: sd_limit};
    assign wipe   = stat_wr ? ~stat_wdata : '0;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic step;
        logic hit;

        assign step = smp_valid && (smp_chan == CH_W'(i));

        ocp_breach_cmp i_cmp (
            .smp (smp_data),
            .thr (thr_vec[i*SMP_W +: SMP_W]),
            .hit (hit)
        );

        ocp_run_counter i_oc_run (
            .clk     (clk),
            .rst     (rst),
            .cfg     (oc_cfg),
            .clr     (wipe[i]),
            .step    (step),
            .hit     (hit),
            .qualify (oc_qual[i])
        );

        ocp_run_counter i_sd_run (
            .clk     (clk),
            .rst     (rst),
            .cfg     (sd_cfg),
            .clr     (1'b0),
            .step    (step),
            .hit     (hit),
            .qualify (sd_qual[i])
        );

        AST_OFF_CODE_SILENT: assert property (@(posedge clk) disable iff (rst)
            (thr_vec[i*SMP_W +: SMP_W] == THR_OFF) |-> !oc_qual[i] && !sd_qual[i]); // R1
    end

    ocp_status_alert #(.NUM_CH(NUM_CH)) i_status (
        .clk      (clk),
        .rst      (rst),
        .qual     (oc_qual),
        .wipe     (wipe),
        .hold     (oc_hold),
        .access   (stat_rd | stat_wr),
        .arb_won  (arb_won),
        .alert_en (alert_en),
        .status   (oc_status),
        .alert    (alert)
    );

    ocp_shutdown_latch #(.NUM_CH(NUM_CH)) i_shutdown (
        .clk      (clk),
        .rst      (rst),
        .qual     (sd_qual),
        .enable   (sd_enable),
        .hold     (sd_hold),
        .shutdown (shutdown)
    );

    AST_ONE_STEP_QUAL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(oc_qual) && $onehot0(sd_qual)); // R3

endmodule

// File: tb/test_ocp_monitor.sv
module test_ocp_monitor;

    logic        clk = 1'b0;
    logic        rst;
    logic        smp_valid;
    logic [1:0]  smp_chan;
    logic [7:0]  smp_data;
    logic [31:0] thr_vec;
    logic [6:0]  oc_limit;
    logic        oc_hold;
    logic [6:0]  sd_limit;
    logic        sd_hold;
    logic        alert_en;
    logic        sd_enable;
    logic        stat_rd;
    logic        stat_wr;
    logic [3:0]  stat_wdata;
    logic        arb_won;
    logic [3:0]  oc_status;
    logic        alert;
    logic        shutdown;

    logic [7:0]  thr [4];
    int          oc_run [4];
    int          sd_run [4];
    logic [3:0]  e_st;
    logic        e_al;
    logic        e_sd;
    int          n_chk = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 4; i++) thr_vec[i*8 +: 8] = thr[i];
    end

    ocp_monitor i_ocp_monitor (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_data(smp_data), .thr_vec(thr_vec), .oc_limit(oc_limit),
        .oc_hold(oc_hold), .sd_limit(sd_limit), .sd_hold(sd_hold),
        .alert_en(alert_en), .sd_enable(sd_enable), .stat_rd(stat_rd),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .arb_won(arb_won),
        .oc_status(oc_status), .alert(alert), .shutdown(shutdown)
    );

    function automatic void levels();
        if (oc_hold) begin
            e_st = '0;
            for (int i = 0; i < 4; i++) oc_run[i] = 0;
        end
        if (!alert_en) e_al = 1'b0;
        if (!sd_enable || sd_hold) begin
            e_sd = 1'b0;
            for (int i = 0; i < 4; i++) sd_run[i] = 0;
        end
    endfunction

    task automatic chk(input string tag);
        n_chk++;
        if (oc_status !== e_st || alert !== e_al || shutdown !== e_sd) begin
            n_bad++;
            $display("FAIL %s status=%h/%h alert=%b/%b shutdown=%b/%b (actual/expected)",
                     tag, oc_status, e_st, alert, e_al, shutdown, e_sd);
        end
    endtask

    task automatic chk_val(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        levels();
        @(negedge clk);
        chk(tag);
    endtask

    task automatic do_sample(input int ch, input int d, input string tag);
        logic hit;
        smp_valid = 1'b1;
        smp_chan  = 2'(ch);
        smp_data  = 8'(d);
        hit = (thr[ch] != 8'hFF) && (d > int'(thr[ch]));
        if (!oc_hold) begin
            if (hit) begin
                if (oc_run[ch] < 255) oc_run[ch]++;
                if (oc_run[ch] >= int'(oc_limit) + 1) begin
                    if (!e_st[ch] && alert_en) e_al = 1'b1;
                    e_st[ch] = 1'b1;
                end
            end else begin
                oc_run[ch] = 0;
            end
        end
        if (sd_enable && !sd_hold) begin
            if (hit) begin
                if (sd_run[ch] < 255) sd_run[ch]++;
                if (sd_run[ch] >= int'(sd_limit) + 1) e_sd = 1'b1;
            end else begin
                sd_run[ch] = 0;
            end
        end
        levels();
        @(negedge clk);
        smp_valid = 1'b0;
        chk(tag);
    endtask

    task automatic stat_write(input logic [3:0] v, input string tag);
        stat_wr    = 1'b1;
        stat_wdata = v;
        for (int i = 0; i < 4; i++) begin
            if (!v[i]) begin
                e_st[i]   = 1'b0;
                oc_run[i] = 0;
            end
        end
        e_al = 1'b0;
        levels();
        @(negedge clk);
        stat_wr = 1'b0;
        chk(tag);
    endtask

    task automatic stat_read(input string tag);
        stat_rd = 1'b1;
        e_al = 1'b0;
        levels();
        @(negedge clk);
        stat_rd = 1'b0;
        chk(tag);
    endtask

    task automatic arb_pulse(input string tag);
        arb_won = 1'b1;
        e_al = 1'b0;
        levels();
        @(negedge clk);
        arb_won = 1'b0;
        chk(tag);
    endtask

    initial begin
        #(20ns * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; smp_valid = 1'b0; smp_chan = '0; smp_data = '0;
        for (int i = 0; i < 4; i++) thr[i] = 8'hD1;
        oc_limit = 7'd4; oc_hold = 1'b0; sd_limit = 7'd20; sd_hold = 1'b0;
        alert_en = 1'b1; sd_enable = 1'b1; stat_rd = 1'b0; stat_wr = 1'b0;
        stat_wdata = '0; arb_won = 1'b0;
        e_st = '0; e_al = 1'b0; e_sd = 1'b0;
        for (int i = 0; i < 4; i++) begin oc_run[i] = 0; sd_run[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset");

        // R2: default delay needs five breaches
        for (int k = 0; k < 4; k++) do_sample(0, 8'hE0, "R2");
        chk_val("R2", int'(oc_status[0]), 0);
        do_sample(0, 8'hE0, "R2");
        chk_val("R2", int'(oc_status[0]), 1);
        chk_val("R6", int'(alert), 1);

        // R7: read clears alert, status stays (R4)
        stat_read("R7");
        chk_val("R7", int'(alert), 0);
        chk_val("R4", int'(oc_status[0]), 1);

        // R4: writing ones keeps, zero clears and needs a full new run
        stat_write(4'hF, "R4");
        chk_val("R4", int'(oc_status[0]), 1);
        stat_write(4'hE, "R4");
        chk_val("R4", int'(oc_status[0]), 0);
        for (int k = 0; k < 4; k++) do_sample(0, 8'hF0, "R4");
        chk_val("R4", int'(oc_status[0]), 0);
        do_sample(0, 8'hF0, "R4");
        chk_val("R4", int'(oc_status[0]), 1);

        // R2: sweep of delay values on channel 1
        for (int n = 0; n < 8; n++) begin
            oc_limit = 7'(n);
            stat_write(4'h0, "R2");
            for (int k = 0; k <= n; k++) begin
                do_sample(1, 8'hD2, "R2");
                chk_val("R2", int'(oc_status[1]), (k == n) ? 1 : 0);
            end
        end

        // R1: strict compare and disabled code
        oc_limit = 7'd0;
        foreach (thr[j]) ;
        for (int t = 0; t < 4; t++) begin
            int tv;
            tv = (t == 0) ? 0 : (t == 1) ? 127 : (t == 2) ? 254 : 255;
            thr[2] = 8'(tv);
            for (int d = tv - 2; d <= tv + 2; d++) begin
                if (d >= 0 && d <= 255) begin
                    stat_write(4'h0, "R1");
                    do_sample(2, d, "R1");
                    chk_val("R1", int'(oc_status[2]), (tv != 255 && d > tv) ? 1 : 0);
                    arb_pulse("R7");
                    chk_val("R7", int'(alert), 0);
                end
            end
        end
        thr[2] = 8'hD1;

        // R3: other channels do not disturb, a miss restarts
        oc_limit = 7'd3;
        stat_write(4'h0, "R3");
        do_sample(0, 8'hE0, "R3");
        do_sample(0, 8'hE0, "R3");
        do_sample(3, 8'hE0, "R3");
        do_sample(1, 8'h10, "R3");
        do_sample(0, 8'hE0, "R3");
        chk_val("R3", int'(oc_status[0]), 0);
        do_sample(0, 8'hE0, "R3");
        chk_val("R3", int'(oc_status[0]), 1);
        stat_write(4'h0, "R3");
        for (int k = 0; k < 3; k++) do_sample(0, 8'hE0, "R3");
        do_sample(0, 8'h20, "R3");
        for (int k = 0; k < 3; k++) do_sample(0, 8'hE0, "R3");
        chk_val("R3", int'(oc_status[0]), 0);

        // R5: hold clears and blocks
        do_sample(0, 8'hE0, "R3");
        oc_hold = 1'b1; tick("R5");
        chk_val("R5", int'(oc_status), 0);
        for (int k = 0; k < 10; k++) do_sample(0, 8'hE0, "R5");
        chk_val("R5", int'(oc_status), 0);
        oc_hold = 1'b0; tick("R5");
        for (int k = 0; k < 3; k++) do_sample(0, 8'hE0, "R5");
        chk_val("R5", int'(oc_status[0]), 0);
        do_sample(0, 8'hE0, "R5");
        chk_val("R5", int'(oc_status[0]), 1);

        // R6: alert disabled
        alert_en = 1'b0; tick("R6");
        stat_write(4'h0, "R6");
        for (int k = 0; k < 4; k++) do_sample(1, 8'hE0, "R6");
        chk_val("R6", int'(oc_status[1]), 1);
        chk_val("R6", int'(alert), 0);
        alert_en = 1'b1; tick("R6");

        // R8: default shutdown delay of 21 samples
        sd_hold = 1'b1; tick("R10");
        sd_hold = 1'b0; sd_limit = 7'd20; tick("R8");
        for (int k = 0; k < 20; k++) do_sample(3, 8'hFE, "R8");
        chk_val("R8", int'(shutdown), 0);
        do_sample(3, 8'hFE, "R8");
        chk_val("R8", int'(shutdown), 1);
        stat_write(4'h0, "R8");
        do_sample(3, 8'h00, "R8");
        chk_val("R8", int'(shutdown), 1);

        // R9: enable low clears and restarts
        sd_enable = 1'b0; tick("R9");
        chk_val("R9", int'(shutdown), 0);
        sd_limit = 7'd2;
        for (int k = 0; k < 4; k++) do_sample(2, 8'hFE, "R9");
        chk_val("R9", int'(shutdown), 0);
        sd_enable = 1'b1; tick("R9");
        do_sample(2, 8'hFE, "R9");
        do_sample(2, 8'hFE, "R9");
        chk_val("R9", int'(shutdown), 0);
        do_sample(2, 8'hFE, "R9");
        chk_val("R9", int'(shutdown), 1);

        // R10: hold forces shutdown low
        sd_hold = 1'b1; tick("R10");
        chk_val("R10", int'(shutdown), 0);
        do_sample(2, 8'hFE, "R10");
        chk_val("R10", int'(shutdown), 0);
        sd_hold = 1'b0; tick("R10");

        // mixed traffic against the arithmetic model
        thr[0] = 8'h40; thr[1] = 8'h80; thr[2] = 8'hC0; thr[3] = 8'hFF;
        for (int it = 0; it < 6000; it++) begin
            int op;
            op = $urandom_range(0, 39);
            case (op)
                0: stat_write(4'($urandom_range(0, 15)), "R4");
                1: stat_read("R7");
                2: arb_pulse("R7");
                3: begin sd_enable = ~sd_enable; tick("R9"); end
                4: begin sd_hold = ~sd_hold; tick("R10"); end
                5: begin oc_hold = ~oc_hold; tick("R5"); end
                6: begin alert_en = ~alert_en; tick("R6"); end
                7: begin oc_limit = 7'($urandom_range(0, 3)); tick("R2"); end
                8: begin sd_limit = 7'($urandom_range(0, 5)); tick("R8"); end
                default: do_sample($urandom_range(0, 3), $urandom_range(0, 255), "R3");
            endcase
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule